// File: doc/BRIEF.md
# Interrupt Pending Arbiter

This block decides which local interrupt a hart should take next, if any. It keeps a 32-bit pending register and combines it with the interrupt-enable mask, the supervisor delegation mask, the current privilege level and the two global enable bits (machine and supervisor). The result is a valid flag and the cause number of the winning interrupt. Selection is combinational; only the pending register is stored.

The pending register changes only through a masked write port. In the cycle of a write the port returns the value held before the update. The masked update lands at the next clock edge. A hard-request line is high whenever the stored pending value is nonzero. Taking the trap, vectoring and claim bookkeeping belong to the surrounding core.

Top module: `irq_pend_arb`

## Requirements
- R1: After synchronous reset the pending register reads zero, `irq_valid` is 0, `irq_cause` is 0 and `hard_req` is 0.
- R2: A write (`wr_en`=1 at a rising edge) stores `(old & ~wr_mask) | (wr_value & wr_mask)`, visible on `pend_out` from the next cycle.
- R3: `wr_old` always shows the pending value held before any write of the current cycle.
- R4: `hard_req` is 1 exactly when the stored pending value is nonzero.
- R5: Only bits set in both the pending register and `int_enable` are candidates; a bit whose enable is 0 is never selected.
- R6: A candidate with its `deleg` bit 0 is taken when `priv` is user (0) or supervisor (1), or when `priv` is machine (3) and `m_gie` is 1.
- R7: A candidate with its `deleg` bit 1 is taken when `priv` is user (0), or when `priv` is supervisor (1) and `s_gie` is 1; it is never taken at machine privilege.
- R8: Among the taken candidates, the lowest-numbered bit wins; `irq_cause` is its bit index.
- R9: With no taken candidate, `irq_valid` is 0 and `irq_cause` is 0.
- R10: With `wr_en`=0 the pending register holds its value whatever `wr_mask` and `wr_value` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Masked write strobe for the pending register |
| wr_mask | input | 32 | Bits of the pending register to replace |
| wr_value | input | 32 | New values for the masked bits |
| wr_old | output | 32 | Pending value before the write of this cycle |
| pend_out | output | 32 | Current pending register |
| int_enable | input | 32 | Per-interrupt enable mask |
| deleg | input | 32 | Per-interrupt delegation to supervisor |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_gie | input | 1 | Global machine interrupt enable |
| s_gie | input | 1 | Global supervisor interrupt enable |
| irq_valid | output | 1 | An interrupt is selected |
| irq_cause | output | 5 | Bit index of the selected interrupt |
| hard_req | output | 1 | Pending register is nonzero |

## Verification
The hardest case to reach is a mixed vector. A low-numbered candidate is blocked by its delegation and privilege combination, and a higher one is open, so the encoder must skip the lower bit. Directed steps first build pending patterns through partial masked writes. They then sweep the privilege and global-enable combinations over delegated and non-delegated bits. Random vectors follow, with sparse pending and enable masks, so that isolated high-numbered winners occur often.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int XLEN    = 32;
    localparam int CAUSE_W = $clog2(XLEN);

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    typedef struct packed {
        logic               valid;
        logic [CAUSE_W-1:0] cause;
    } arb_pick_t;

    // Interrupts routed to machine level are open below machine or with the global bit.
    function automatic logic mach_open(priv_e p, logic gie);
        return (p != PRIV_MACH) || gie;
    endfunction

    // Interrupts routed to supervisor level are open in user mode, or in supervisor with the global bit.
    function automatic logic super_open(priv_e p, logic gie);
        return (p == PRIV_USER) || ((p == PRIV_SUPER) && gie);
    endfunction
endpackage

// File: rtl/irq_pend_store.sv
module irq_pend_store
    import irq_arb_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_mask,
    input  logic [W-1:0] wr_value,
    output logic [W-1:0] pend_q,
    output logic [W-1:0] old_value
);
    logic [W-1:0] pend_next;

    always_comb begin
        pend_next = (pend_q & ~wr_mask) | (wr_value & wr_mask);
        old_value = pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (wr_en) begin
            pend_q <= pend_next;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(pend_q)) else $error("pending changed without write"); // R10

    AST_UNMASKED_KEEP: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (((pend_q ^ $past(pend_q)) & ~$past(wr_mask)) == '0)) else $error("unmasked bit changed"); // R2
endmodule

// File: rtl/irq_enable_gate.sv
module irq_enable_gate
    import irq_arb_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] pend,
    input  logic [W-1:0] ie,
    input  logic [W-1:0] deleg,
    input  priv_e        priv,
    input  logic         m_gie,
    input  logic         s_gie,
    output logic [W-1:0] taken
);
    logic         m_ok;
    logic         s_ok;
    logic [W-1:0] route_ok;

    always_comb begin
        m_ok     = mach_open(priv, m_gie);
        s_ok     = super_open(priv, s_gie);
        route_ok = (~deleg & {W{m_ok}}) | (deleg & {W{s_ok}});
        taken    = pend & ie & route_ok;
    end
endmodule

// File: rtl/irq_low_first.sv
module irq_low_first
    import irq_arb_pkg::*;
#(
    parameter int W  = XLEN,
    localparam int CW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          any,
    output logic [CW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = CW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_pend_arb.sv
module irq_pend_arb
    import irq_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [XLEN-1:0]    wr_mask,
    input  logic [XLEN-1:0]    wr_value,
    output logic [XLEN-1:0]    wr_old,
    output logic [XLEN-1:0]    pend_out,
    input  logic [XLEN-1:0]    int_enable,
    input  logic [XLEN-1:0]    deleg,
    input  logic [1:0]         priv,
    input  logic               m_gie,
    input  logic               s_gie,
    output logic               irq_valid,
    output logic [CAUSE_W-1:0] irq_cause,
    output logic               hard_req
);
    logic [XLEN-1:0] pend_q;
    logic [XLEN-1:0] taken;
    arb_pick_t       pick;
    priv_e           priv_l;

    assign priv_l = priv_e'(priv);

    irq_pend_store #(.W(XLEN)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_mask   (wr_mask),
        .wr_value  (wr_value),
        .pend_q    (pend_q),
        .old_value (wr_old)
    );

    irq_enable_gate #(.W(XLEN)) u_gate (
        .pend  (pend_q),
        .ie    (int_enable),
        .deleg (deleg),
        .priv  (priv_l),
        .m_gie (m_gie),
        .s_gie (s_gie),
        .taken (taken)
    );

    irq_low_first #(.W(XLEN)) u_pick (
        .req (taken),
        .any (pick.valid),
        .idx (pick.cause)
    );

    assign pend_out  = pend_q;
    assign irq_valid = pick.valid;
    assign irq_cause = pick.cause;
    assign hard_req  = |pend_q;

    AST_VALID_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> hard_req) else $error("selection without pending"); // R4

    AST_CAUSE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (pend_q[irq_cause] && int_enable[irq_cause])) else $error("disabled cause chosen"); // R5

    AST_DELEG_MACH_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && priv_l == PRIV_MACH) |-> !deleg[irq_cause]) else $error("delegated taken in machine"); // R7

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> ((taken & ((XLEN'(1) << irq_cause) - XLEN'(1))) == '0)) else $error("lower candidate skipped"); // R8

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !irq_valid |-> (irq_cause == '0)) else $error("cause nonzero when idle"); // R9
endmodule

// File: tb/irq_pend_arb_test.sv
module irq_pend_arb_test;
    localparam int  W      = 32;
    localparam time PERIOD = 8ns;

    typedef struct {
        string       tag;
        logic [31:0] pend;
        logic [31:0] old;
        logic        hard;
        logic        valid;
        logic [4:0]  cause;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_mask = '0, wr_value = '0, int_enable = '0, deleg = '0;
    logic [1:0]  priv = 2'd0;
    logic        m_gie = 1'b0, s_gie = 1'b0;
    logic [31:0] wr_old, pend_out;
    logic        irq_valid, hard_req;
    logic [4:0]  irq_cause;

    int checks = 0;
    int fails  = 0;
    logic [31:0] shadow = '0;
    exp_t sb[$];
    event sample_ev;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    irq_pend_arb uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mask(wr_mask), .wr_value(wr_value),
        .wr_old(wr_old), .pend_out(pend_out), .int_enable(int_enable), .deleg(deleg),
        .priv(priv), .m_gie(m_gie), .s_gie(s_gie), .irq_valid(irq_valid),
        .irq_cause(irq_cause), .hard_req(hard_req)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per sample event and compares.
    initial begin
        forever begin
            @(sample_ev);
            if (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, "/R2"}, "pend_out", pend_out, e.pend);
                check({e.tag, "/R3"}, "wr_old", wr_old, e.old);
                check({e.tag, "/R4"}, "hard_req", {31'd0, hard_req}, {31'd0, e.hard});
                check(e.tag, "irq_valid", {31'd0, irq_valid}, {31'd0, e.valid});
                check({e.tag, "/R9"}, "irq_cause", {27'd0, irq_cause}, {27'd0, e.cause});
            end
        end
    end

    // Reference model of selection, written from R5 to R9.
    function automatic exp_t model(logic [31:0] p, logic [31:0] ie, logic [31:0] dl,
                                   logic [1:0] pv, logic mg, logic sg);
        exp_t e;
        logic mo, so;
        logic [31:0] en;
        mo = (pv == 2'd0) || (pv == 2'd1) || (pv == 2'd3 && mg);
        so = (pv == 2'd0) || (pv == 2'd1 && sg);
        en = 32'd0;
        for (int i = 0; i < W; i++)
            en[i] = p[i] && ie[i] && (dl[i] ? so : mo);
        e.valid = 1'b0;
        e.cause = 5'd0;
        for (int i = 0; i < W; i++)
            if (!e.valid && en[i]) begin
                e.valid = 1'b1;
                e.cause = 5'(i);
            end
        e.pend = p;
        e.old  = p;
        e.hard = (p != 0);
        return e;
    endfunction

    // Driver: applies one cycle of stimulus and pushes the expected outputs.
    task automatic step(string tag, logic we, logic [31:0] m, logic [31:0] v,
                        logic [31:0] ie, logic [31:0] dl, logic [1:0] pv, logic mg, logic sg);
        exp_t e;
        @(negedge clk);
        wr_en = we; wr_mask = m; wr_value = v;
        int_enable = ie; deleg = dl; priv = pv; m_gie = mg; s_gie = sg;
        e = model(shadow, ie, dl, pv, mg, sg);
        e.tag = tag;
        sb.push_back(e);
        #1;
        ->sample_ev;
        @(posedge clk);
        if (we) shadow = (shadow & ~m) | (v & m);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        step("R1", 0, '0, '0, 32'hFFFF_FFFF, '0, 2'd3, 1, 1);
        // R2 / R3: masked writes
        step("R2", 1, 32'hFFFF_0000, 32'hA5A5_A5A5, '0, '0, 2'd3, 1, 0);
        step("R2", 1, 32'h0000_00FF, 32'h1234_5678, '0, '0, 2'd3, 1, 0);
        step("R3", 0, '0, '0, '0, '0, 2'd3, 1, 0);
        // R10: no write, noisy mask and value
        step("R10", 0, 32'hFFFF_FFFF, 32'h0000_0000, '0, '0, 2'd3, 1, 0);
        step("R10", 0, '0, '0, '0, '0, 2'd3, 1, 0);
        // R4: clear all then set one bit
        step("R4", 1, 32'hFFFF_FFFF, 32'h0, '0, '0, 2'd3, 1, 0);
        step("R4", 1, 32'h0000_0800, 32'hFFFF_FFFF, '0, '0, 2'd3, 1, 0);
        // Build pending bits 3, 7, 11
        step("R2", 1, 32'h0000_0088, 32'h0000_0088, '0, '0, 2'd3, 1, 0);
        // R5: enable masks out bit 3, so 7 wins
        step("R5", 0, '0, '0, 32'hFFFF_FFF7, '0, 2'd3, 1, 0);
        step("R5", 0, '0, '0, 32'h0000_0800, '0, 2'd3, 1, 0);
        // R6: non-delegated
        step("R6", 0, '0, '0, 32'hFFFF_FFFF, '0, 2'd3, 0, 1);
        step("R6", 0, '0, '0, 32'hFFFF_FFFF, '0, 2'd3, 1, 0);
        step("R6", 0, '0, '0, 32'hFFFF_FFFF, '0, 2'd1, 0, 0);
        step("R6", 0, '0, '0, 32'hFFFF_FFFF, '0, 2'd0, 0, 0);
        // R7: delegated
        step("R7", 0, '0, '0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd3, 1, 1);
        step("R7", 0, '0, '0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd1, 1, 0);
        step("R7", 0, '0, '0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd1, 0, 1);
        step("R7", 0, '0, '0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd0, 0, 0);
        // R8: bit 3 delegated and blocked in machine mode, 7 machine-level and open
        step("R8", 0, '0, '0, 32'hFFFF_FFFF, 32'h0000_0008, 2'd3, 1, 1);
        step("R8", 0, '0, '0, 32'hFFFF_FFFF, 32'h0000_0080, 2'd1, 0, 0);
        // R9: nothing open
        step("R9", 0, '0, '0, 32'h0000_0000, '0, 2'd0, 1, 1);
        // R8: random vectors against the model
        for (int n = 0; n < 1500; n++) begin
            logic [31:0] m, v, ie, dl;
            logic [1:0]  pv;
            m  = $urandom();
            v  = $urandom() & $urandom();
            ie = $urandom() & $urandom();
            dl = $urandom();
            pv = 2'($urandom_range(0, 2));
            if (pv == 2'd2) pv = 2'd3;
            step("R8", 1'($urandom()), m, v, ie, dl, pv, 1'($urandom()), 1'($urandom()));
        end
        step("R2", 0, '0, '0, '0, '0, 2'd0, 0, 0);
        done = 1;
        summary();
    end
endmodule